// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side master for an 8-channel, 10-bit serial converter that is run with its conversion clocked by the serial clock itself. A one-cycle `start` pulse launches a complete conversion. The sequencer takes the channel number, the single-ended/differential choice and the unipolar/bipolar choice from its configuration inputs. It packs them into a command byte, pulls chip select low, and clocks three 8-bit transfers (24 serial clocks). It then releases chip select.

Only the last 16 bits received carry data. The sequencer pulls out the 10-bit conversion code and the two extra bits below its LSB. It also builds a 16-bit extended form, which is zero-extended for unipolar and sign-extended for bipolar. It reports the result with a one-cycle `done` strobe. The time with chip select low is measured against a limit (120 µs by default), and `time_err` reports whether the limit was exceeded. The serial clock rate and an optional idle gap between bytes are set by parameters.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, and whenever `spi_cs_n` is high, `spi_sclk` is low. After reset, `spi_cs_n` is high and `busy` and `done` are low.
- R2: The first byte shifted out is {1, chan[2:0], unipolar, single, 1, 1}, sent from bit 7 down to bit 0. Bit 3 is 1 for unipolar coding and bit 2 is 1 for single-ended input. `chan` picks a channel, or a channel pair in differential mode.
- R3: A frame has exactly 24 rising `spi_sclk` edges while `spi_cs_n` is low. The last 16 bits sent on `spi_mosi` are all 0. `done` is high in the first cycle in which `spi_cs_n` is high again.
- R4: `spi_mosi` changes during a frame only in the cycle in which `spi_sclk` falls. The first bit is driven together with the falling edge of `spi_cs_n`.
- R5: The 8 bits received during the command byte have no effect on `result`, `sub_lsb` or `result_ext`.
- R6: `spi_miso` is sampled when `spi_sclk` rises. If the last 16 samples form the word W[15:0], with the first of them as W[15], then `result` = W[14:5] and `sub_lsb` = W[4:3].
- R7: `result_ext` is `result` zero-extended to 16 bits when the frame was started with `cfg_unipolar`=1, and sign-extended from bit 9 otherwise.
- R8: `time_err` is 1 exactly when the frame held `spi_cs_n` low for more than LIMIT_US microseconds of system clocks, gap cycles included.
- R9: `busy` rises in the cycle after an accepted `start` and falls with `done`. `start` and configuration changes while busy have no effect on the running frame, and no second frame follows.
- R10: `done` lasts one cycle. `result`, `sub_lsb`, `result_ext` and `time_err` hold their values until the next `done`.
- R11: Each `spi_sclk` level lasts HALF = ceil(SYS_CLK_HZ / (2·SCLK_HZ)) system clocks. After bytes 1 and 2, `spi_sclk` stays low for GAP_CLKS extra clocks. `spi_cs_n` is therefore low for exactly 48·HALF + 2·GAP_CLKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| cfg_chan | input | 3 | Channel (or pair) selection |
| cfg_single | input | 1 | 1 = single-ended, 0 = differential |
| cfg_unipolar | input | 1 | 1 = unipolar (binary), 0 = bipolar (two's complement) |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 10 | Conversion code |
| sub_lsb | output | 2 | Two bits below the code LSB |
| result_ext | output | 16 | Code zero- or sign-extended |
| time_err | output | 1 | Frame exceeded the time limit |

## Verification
The bench builds three copies at a 50 MHz system clock and a 2 MHz serial clock request, which gives HALF = 13 and 624 clocks per frame. The first copy uses no gap and the full 120 µs limit, and it carries the random and directed traffic. The second and third copies use a 15 µs limit (750 clocks) with gaps of 63 and 64 clocks. This puts the frame length exactly on the limit and one step beyond it, so both sides of the timeout boundary and the gap timing become observable in a short run.

// File: rtl/adc_seq_pkg.sv
// Package: shared state type, frame constants and command-byte builder
// for the serial ADC conversion sequencer.
package adc_seq_pkg;

    localparam int FRAME_BITS = 24;
    localparam int BYTE_BITS  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_t;

    // Packs the command byte: start bit, selection, coding, input type, clock mode.
    function automatic logic [7:0] build_cmd(input logic [2:0] chan,
                                             input logic       unipolar,
                                             input logic       single);
        return {1'b1, chan, unipolar, single, 2'b11};
    endfunction

endpackage

// File: rtl/seq_half_timer.sv
// Half-period timer: while run is high, pulses tick once every HALF_CLKS
// system clocks. Assumes HALF_CLKS >= 1. It restarts from zero whenever run drops.
module seq_half_timer #(
    parameter int HALF_CLKS = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_q;

    // Count system clocks within one serial-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    p_half_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(cnt_q) != LAST) |-> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/seq_elapsed_mon.sv
// Elapsed-time monitor: counts the cycles in which count_en is high after clear,
// saturating at LIMIT_CLKS. over is high once LIMIT_CLKS cycles have been counted.
// So a frame that ends in the cycle where over is sampled lasted more than LIMIT_CLKS.
module seq_elapsed_mon #(
    parameter int LIMIT_CLKS = 6000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic over
);
    localparam int CW = $clog2(LIMIT_CLKS + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT_CLKS);

    logic [CW-1:0] cnt_q;

    // Saturating frame-duration counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (count_en && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over = (cnt_q == LIM);

    p_over_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (over && !clear) |=> over);

endmodule

// File: rtl/seq_result_fmt.sv
// Result formatter: splits the received 16-bit word into code and sub-LSB bits.
// It builds a zero- or sign-extended copy. Purely combinational.
module seq_result_fmt #(
    parameter int CODE_W = 10,
    parameter int EXT_W  = 16
) (
    input  logic [15:0]       word,
    input  logic              bipolar,
    output logic [CODE_W-1:0] code,
    output logic [1:0]        sub,
    output logic [EXT_W-1:0]  ext
);
    localparam int PAD = EXT_W - CODE_W;

    // Field extraction and extension.
    always_comb begin
        code = word[14 -: CODE_W];
        sub  = word[4:3];
        ext  = {{PAD{bipolar & code[CODE_W-1]}}, code};
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Serial ADC conversion sequencer. On an accepted start it sends the command
// byte and two zero bytes as serial-bus mode 0 (clock idles low, data driven on the
// falling edge, sampled on the rising edge). It then formats the last 16 bits received.
// Assumes spi_miso is synchronous to clk through the slow serial clock.
module adc_conv_seq #(
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int SCLK_HZ    = 2_000_000,
    parameter int GAP_CLKS   = 0,
    parameter int LIMIT_US   = 120
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  cfg_chan,
    input  logic        cfg_single,
    input  logic        cfg_unipolar,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        busy,
    output logic        done,
    output logic [9:0]  result,
    output logic [1:0]  sub_lsb,
    output logic [15:0] result_ext,
    output logic        time_err
);
    import adc_seq_pkg::*;

    localparam int HALF_CLKS  = (SYS_CLK_HZ + 2 * SCLK_HZ - 1) / (2 * SCLK_HZ);
    localparam int LIMIT_CLKS = (SYS_CLK_HZ / 1_000_000) * LIMIT_US;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int GAP_W      = $clog2(GAP_CLKS + 2);
    localparam logic [GAP_W-1:0] GAP_LAST = (GAP_CLKS > 0) ? GAP_W'(GAP_CLKS - 1) : '0;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
    localparam bit   HAS_GAP  = (GAP_CLKS > 0);

    seq_state_t              state_q;
    logic [IDX_W-1:0]        idx_q;
    logic [FRAME_BITS-1:0]   tx_q;
    logic [FRAME_BITS-1:0]   rx_q;
    logic [GAP_W-1:0]        gap_q;
    logic                    sclk_q, cs_n_q, bip_q, busy_q, done_q, err_q;
    logic [9:0]              res_q;
    logic [1:0]              sub_q;
    logic [15:0]             ext_q;

    logic                    tick, over, accept, byte_end;
    logic [9:0]              f_code;
    logic [1:0]              f_sub;
    logic [15:0]             f_ext;

    assign accept   = (state_q == ST_IDLE) && start;
    assign byte_end = (idx_q[2:0] == 3'd7);

    seq_half_timer #(.HALF_CLKS(HALF_CLKS)) u_half (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_SHIFT),
        .tick (tick)
    );

    seq_elapsed_mon #(.LIMIT_CLKS(LIMIT_CLKS)) u_mon (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .count_en(state_q != ST_IDLE),
        .over    (over)
    );

    seq_result_fmt #(.CODE_W(10), .EXT_W(16)) u_fmt (
        .word   (rx_q[15:0]),
        .bipolar(bip_q),
        .code   (f_code),
        .sub    (f_sub),
        .ext    (f_ext)
    );

    // Frame sequencer: launch, clock edges, byte gaps and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            gap_q   <= '0;
            sclk_q  <= 1'b0;
            cs_n_q  <= 1'b1;
            bip_q   <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            res_q   <= '0;
            sub_q   <= '0;
            ext_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tx_q    <= {build_cmd(cfg_chan, cfg_unipolar, cfg_single), 16'h0000};
                        bip_q   <= ~cfg_unipolar;
                        idx_q   <= '0;
                        cs_n_q  <= 1'b0;
                        busy_q  <= 1'b1;
                        state_q <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick && !sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[FRAME_BITS-2:0], spi_miso};
                    end else if (tick) begin
                        sclk_q <= 1'b0;
                        tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
                        if (idx_q == IDX_LAST) begin
                            cs_n_q  <= 1'b1;
                            busy_q  <= 1'b0;
                            done_q  <= 1'b1;
                            res_q   <= f_code;
                            sub_q   <= f_sub;
                            ext_q   <= f_ext;
                            err_q   <= over;
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            if (HAS_GAP && byte_end) begin
                                gap_q   <= '0;
                                state_q <= ST_GAP;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        state_q <= ST_SHIFT;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign spi_sclk   = sclk_q;
    assign spi_cs_n   = cs_n_q;
    assign spi_mosi   = tx_q[FRAME_BITS-1];
    assign busy       = busy_q;
    assign done       = done_q;
    assign result     = res_q;
    assign sub_lsb    = sub_q;
    assign result_ext = ext_q;
    assign time_err   = err_q;

    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> (!spi_cs_n && spi_mosi));

    p_done_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_cs_n && $past(!spi_cs_n)));

    p_mosi_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !$fell(spi_sclk)) |-> $stable(spi_mosi));

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_adc_conv_seq.sv
// Pin-level model of the converter: records the command byte and trailing bits
// on rising sclk. It shifts a preset 16-bit word out on falling sclk, and drives ones
// during the command byte.
module adc_pin_model (
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    input  logic [15:0] word,
    output logic        miso,
    output logic [7:0]  cmd,
    output logic [15:0] tail,
    output int          rises
);
    logic miso_q = 1'b1;
    assign miso = miso_q;

    always @(negedge cs_n or posedge sclk) begin
        if (!sclk) begin
            rises = 0;
            cmd   = 8'h00;
            tail  = 16'hFFFF;
        end else if (!cs_n) begin
            if (rises < 8) cmd = {cmd[6:0], mosi};
            else           tail = {tail[14:0], mosi};
            rises = rises + 1;
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            if (rises >= 8 && rises <= 23) miso_q = word[23 - rises];
            else                           miso_q = 1'b1;
        end
    end
endmodule

module sim_adc_conv_seq;
    localparam int HALF = 13;                  // ceil(50 MHz / (2 * 2 MHz))
    localparam int GAPV [3] = '{0, 63, 64};
    localparam int LIMV [3] = '{6000, 750, 750};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        start   [3];
    logic [2:0]  chan    [3];
    logic        single  [3];
    logic        uni     [3];
    logic        sclk    [3];
    logic        cs_n    [3];
    logic        mosi    [3];
    logic        miso    [3];
    logic        busy    [3];
    logic        done    [3];
    logic [9:0]  res     [3];
    logic [1:0]  sub     [3];
    logic [15:0] ext     [3];
    logic        terr    [3];
    logic [15:0] word    [3];
    logic [7:0]  cmd     [3];
    logic [15:0] tail    [3];
    int          rises   [3];

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    adc_conv_seq #(.GAP_CLKS(0), .LIMIT_US(120)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start[0]), .cfg_chan(chan[0]),
        .cfg_single(single[0]), .cfg_unipolar(uni[0]), .spi_sclk(sclk[0]),
        .spi_cs_n(cs_n[0]), .spi_mosi(mosi[0]), .spi_miso(miso[0]), .busy(busy[0]),
        .done(done[0]), .result(res[0]), .sub_lsb(sub[0]), .result_ext(ext[0]),
        .time_err(terr[0]));
    adc_conv_seq #(.GAP_CLKS(63), .LIMIT_US(15)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start[1]), .cfg_chan(chan[1]),
        .cfg_single(single[1]), .cfg_unipolar(uni[1]), .spi_sclk(sclk[1]),
        .spi_cs_n(cs_n[1]), .spi_mosi(mosi[1]), .spi_miso(miso[1]), .busy(busy[1]),
        .done(done[1]), .result(res[1]), .sub_lsb(sub[1]), .result_ext(ext[1]),
        .time_err(terr[1]));
    adc_conv_seq #(.GAP_CLKS(64), .LIMIT_US(15)) u2 (
        .clk(clk), .rst_n(rst_n), .start(start[2]), .cfg_chan(chan[2]),
        .cfg_single(single[2]), .cfg_unipolar(uni[2]), .spi_sclk(sclk[2]),
        .spi_cs_n(cs_n[2]), .spi_mosi(mosi[2]), .spi_miso(miso[2]), .busy(busy[2]),
        .done(done[2]), .result(res[2]), .sub_lsb(sub[2]), .result_ext(ext[2]),
        .time_err(terr[2]));

    adc_pin_model m0 (.sclk(sclk[0]), .cs_n(cs_n[0]), .mosi(mosi[0]), .word(word[0]),
                      .miso(miso[0]), .cmd(cmd[0]), .tail(tail[0]), .rises(rises[0]));
    adc_pin_model m1 (.sclk(sclk[1]), .cs_n(cs_n[1]), .mosi(mosi[1]), .word(word[1]),
                      .miso(miso[1]), .cmd(cmd[1]), .tail(tail[1]), .rises(rises[1]));
    adc_pin_model m2 (.sclk(sclk[2]), .cs_n(cs_n[2]), .mosi(mosi[2]), .word(word[2]),
                      .miso(miso[2]), .cmd(cmd[2]), .tail(tail[2]), .rises(rises[2]));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input logic [2:0] c, input logic u, input logic s);
        return {1'b1, c, u, s, 2'b11};
    endfunction

    function automatic logic [15:0] exp_ext(input logic [9:0] c, input logic u);
        return u ? {6'b0, c} : {{6{c[9]}}, c};
    endfunction

    // One full frame on instance i, with an optional ignored start and config change mid-frame.
    task automatic run_frame(input int i, input logic [2:0] c, input logic s, input logic u,
                             input logic [9:0] code, input logic [1:0] sb, input bit poke);
        int low = 0;
        int cyc = 0;
        bit busy_ok = 1;
        chan[i] = c; single[i] = s; uni[i] = u;
        word[i] = {1'b0, code, sb, 3'b000};
        @(negedge clk) start[i] = 1'b1;
        @(negedge clk) start[i] = 1'b0;
        while (!done[i] && cyc < 20000) begin
            if (!cs_n[i]) low++;
            if (!busy[i]) busy_ok = 0;
            if (poke && cyc == 40) begin
                start[i] = 1'b1; chan[i] = ~c; single[i] = ~s; uni[i] = ~u;
            end
            if (poke && cyc == 41) start[i] = 1'b0;
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 20000) chk("watchdog frame", 0, 1);
        chk("R9 busy held through frame", int'(busy_ok), 1);
        chk("R9 busy low at done", int'(busy[i]), 0);
        chk("R2 command byte", int'(cmd[i]), int'(exp_cmd(c, u, s)));
        chk("R3 rising sclk edges", rises[i], 24);
        chk("R3 trailing bytes zero", int'(tail[i]), 0);
        chk("R3 cs high at done", int'(cs_n[i]), 1);
        chk("R11 cs low length", low, 48 * HALF + 2 * GAPV[i]);
        chk("R6 result", int'(res[i]), int'(code));
        chk("R6 sub-LSB", int'(sub[i]), int'(sb));
        chk("R7 extended result", int'(ext[i]), int'(exp_ext(code, u)));
        chk("R8 time error", int'(terr[i]), int'((48 * HALF + 2 * GAPV[i]) > LIMV[i]));
        chan[i] = c; single[i] = s; uni[i] = u;
        @(negedge clk);
        chk("R10 done single cycle", int'(done[i]), 0);
        repeat (4) @(negedge clk);
        chk("R10 result held", int'(res[i]), int'(code));
        chk("R10 extended held", int'(ext[i]), int'(exp_ext(code, u)));
        chk("R9 no second frame", int'(cs_n[i]), 1);
        chk("R1 sclk idle low", int'(sclk[i]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        int seed = $urandom(32'h5EED_0A4C);
        for (int i = 0; i < 3; i++) begin
            start[i] = 0; chan[i] = 0; single[i] = 1; uni[i] = 1; word[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            chk("R1 reset cs high", int'(cs_n[i]), 1);
            chk("R1 reset sclk low", int'(sclk[i]), 0);
            chk("R1 reset busy low", int'(busy[i]), 0);
            chk("R1 reset done low", int'(done[i]), 0);
        end
        // R5: all-zero code while the command byte returns ones
        run_frame(0, 3'd5, 1'b1, 1'b1, 10'h000, 2'b00, 1'b0);
        run_frame(0, 3'd0, 1'b0, 1'b0, 10'h200, 2'b11, 1'b0);
        run_frame(0, 3'd7, 1'b1, 1'b1, 10'h3FF, 2'b01, 1'b0);
        run_frame(0, 3'd2, 1'b0, 1'b0, 10'h1FF, 2'b10, 1'b1);
        for (int k = 0; k < 30; k++) begin
            run_frame(0, 3'($urandom), 1'($urandom), 1'($urandom),
                      10'($urandom), 2'($urandom), bit'(k % 5 == 0));
        end
        run_frame(1, 3'd3, 1'b1, 1'b0, 10'h2AA, 2'b01, 1'b0);
        run_frame(2, 3'd4, 1'b0, 1'b1, 10'h155, 2'b10, 1'b1);
        if (seed == 0) chk("seed", 0, 0);
        report();
        $finish;
    end
endmodule